// File: doc/BRIEF.md
# Rising-Edge Pending Flag Bank with Secure and Privileged Access Filtering

This block holds one pending flag per external event line. A flag is raised when its event input goes from low to high (after a two-flop synchronizer) or when software pulses that line's trigger input. Software sees the flags through a simple register read port. It clears a flag by writing a 1 to that flag's bit position. The flag vector is also driven out continuously, for use by the interrupt logic that sits next to this block.

Every register access carries two attributes: a secure bit and a privileged bit. Each line has a security configuration bit and a privilege configuration bit. A line marked secure only answers secure accesses. A line marked privileged only answers privileged accesses. The two checks are independent, and an access must pass both. A blocked write leaves the bit alone, and a blocked read shows 0 in that bit only; all other bits behave normally.

The number of lines is a parameter, and a presence mask parameter removes optional lines. Bit positions from the line count up to the register width are reserved.

Top module: `rise_pend_bank`

## Requirements
- R1: Line i is mapped to bit i of both `rdata` and `pend_out`. `rdata` bits NLINES to 31 (26..31 by default) always read 0.
- R2: While `rst` is high, and after it falls, all flags, `pend_out` and `rdata` are 0.
- R3: When `evt_in[i]` is sampled high at a rising clock edge after being sampled low at the edge before, flag i becomes visible on `pend_out` after the third rising edge that sees it high. A level that stays high, or a falling level, does not set the flag again.
- R4: When `sw_trig[i]` is high at a rising edge, flag i is 1 after that edge.
- R5: A permitted write with `wdata[i]`=1 clears flag i at that edge. A write with `wdata[i]`=0 leaves flag i unchanged.
- R6: When `sec_cfg[i]`=1, a write with `acc_secure`=0 does not change flag i, and a read with `acc_secure`=0 returns 0 in bit i. When `sec_cfg[i]`=0, both secure and non-secure accesses reach bit i.
- R7: When `priv_cfg[i]`=1, a write with `acc_priv`=0 does not change flag i, and a read with `acc_priv`=0 returns 0 in bit i. When `priv_cfg[i]`=0, both privileged and unprivileged accesses reach bit i.
- R8: The security check and the privilege check are applied independently. Bit i is reached only when it passes both checks. A blocked bit does not affect the other bits of the same access.
- R9: If a set (edge or trigger) and a permitted write-1 clear hit the same bit at the same edge, the bit is 1 afterwards.
- R10: A line whose bit in `LINE_MASK` is 0 is absent. Its flag stays 0 whatever its inputs do, it reads as 0, and writes to it have no effect.
- R11: `rdata` is a register. It is loaded at a rising edge where `rd_en`=1, with the filtered flag values from before that edge, and it holds its value at all other edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_in | input | NLINES | Asynchronous event lines |
| sw_trig | input | NLINES | Software trigger pulses, one per line |
| sec_cfg | input | NLINES | Per-line security configuration (1 = secure only) |
| priv_cfg | input | NLINES | Per-line privilege configuration (1 = privileged only) |
| wr_en | input | 1 | Write strobe for the pending register |
| rd_en | input | 1 | Read strobe for the pending register |
| wdata | input | 32 | Write data; a 1 clears the matching flag |
| acc_secure | input | 1 | Access attribute: secure |
| acc_priv | input | 1 | Access attribute: privileged |
| rdata | output | 32 | Registered, filtered read data |
| pend_out | output | NLINES | Pending flag vector for interrupt generation |

## Verification
The bench configures the block with line 24 absent. It sweeps all four combinations of the access attributes against interleaved security and privilege patterns, so that a filter that swaps the two checks, combines them with OR, or filters a whole word instead of single bits returns the wrong read mask or clears the wrong flags. It times the edge path exactly, so an extra or missing synchronizer stage shows up as a flag one cycle early or late, and it holds the input high to catch a level-sensitive detector that raises the flag again after a clear. It fires a trigger and a clear on the same bit in the same cycle to catch a design where the clear wins. It also drives the absent line, the write-0 case and the read-hold case, which catch a presence mask that leaks, a clear on 0, and a read register that follows the flags.

// File: rtl/rpb_pkg.sv
package rpb_pkg;
  localparam int REG_W = 32;

  typedef struct packed {
    logic secure;
    logic priv;
  } acc_attr_t;
endpackage

// File: rtl/rpb_edge_detect.sv
module rpb_edge_detect #(
  parameter int N = 26
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] rise
);
  logic [N-1:0] stage1, stage2, prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      stage2 <= '0;
      prev   <= '0;
    end else begin
      stage1 <= din;
      stage2 <= stage1;
      prev   <= stage2;
    end
  end

  assign rise = stage2 & ~prev;
endmodule

// File: rtl/rpb_access_gate.sv
module rpb_access_gate
  import rpb_pkg::*;
#(
  parameter int N = 26,
  parameter logic [N-1:0] MASK = '1
) (
  input  acc_attr_t    attr,
  input  logic [N-1:0] sec_cfg,
  input  logic [N-1:0] priv_cfg,
  output logic [N-1:0] allow
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    if (MASK[i]) begin : g_on
      assign allow[i] = (attr.secure | ~sec_cfg[i]) & (attr.priv | ~priv_cfg[i]);
    end else begin : g_off
      assign allow[i] = 1'b0;
    end
  end
endmodule

// File: rtl/rpb_flag_bank.sv
module rpb_flag_bank #(
  parameter int N = 26,
  parameter logic [N-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    if (MASK[i]) begin : g_on
      logic q;
      always_ff @(posedge clk) begin
        if (rst)             q <= 1'b0;
        else if (set_vec[i]) q <= 1'b1;
        else if (clr_vec[i]) q <= 1'b0;
      end
      assign flags[i] = q;
    end else begin : g_off
      assign flags[i] = 1'b0;
    end
  end
endmodule

// File: rtl/rise_pend_bank.sv
module rise_pend_bank
  import rpb_pkg::*;
#(
  parameter int NLINES = 26,
  parameter logic [NLINES-1:0] LINE_MASK = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLINES-1:0] evt_in,
  input  logic [NLINES-1:0] sw_trig,
  input  logic [NLINES-1:0] sec_cfg,
  input  logic [NLINES-1:0] priv_cfg,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [31:0]       wdata,
  input  logic              acc_secure,
  input  logic              acc_priv,
  output logic [31:0]       rdata,
  output logic [NLINES-1:0] pend_out
);
  localparam int RSV_W = REG_W - NLINES;

  acc_attr_t         attr;
  logic [NLINES-1:0] rise_vec, allow_vec, set_vec, clr_vec, flags;
  logic              unused_hi;

  assign attr      = '{secure: acc_secure, priv: acc_priv};
  assign unused_hi = ^wdata[REG_W-1:NLINES];

  rpb_edge_detect #(.N(NLINES)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .din  (evt_in),
    .rise (rise_vec)
  );

  rpb_access_gate #(.N(NLINES), .MASK(LINE_MASK)) u_gate (
    .attr     (attr),
    .sec_cfg  (sec_cfg),
    .priv_cfg (priv_cfg),
    .allow    (allow_vec)
  );

  assign set_vec = rise_vec | sw_trig;
  assign clr_vec = wr_en ? (wdata[NLINES-1:0] & allow_vec) : '0;

  rpb_flag_bank #(.N(NLINES), .MASK(LINE_MASK)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .flags   (flags)
  );

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= {{RSV_W{1'b0}}, flags & allow_vec};
  end

  assign pend_out = flags;
endmodule

// File: rtl/rpb_checker.sv
module rpb_checker #(
  parameter int N = 26,
  parameter logic [N-1:0] MASK = '1
) (
  input logic         clk,
  input logic         rst,
  input logic         wr_en,
  input logic         rd_en,
  input logic         acc_secure,
  input logic         acc_priv,
  input logic [N-1:0] sec_cfg,
  input logic [N-1:0] priv_cfg,
  input logic [N-1:0] sw_trig,
  input logic [N-1:0] rise,
  input logic [N-1:0] pend_out,
  input logic [31:0]  rdata
);
  logic [N-1:0] ok_c;
  assign ok_c = MASK & ({N{acc_secure}} | ~sec_cfg) & ({N{acc_priv}} | ~priv_cfg);

  // R1
  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    rdata[31:N] == '0);
  // R4 and R9: a trigger always leaves its flag set, even against a clear
  a_r4_trig_sets: assert property (@(posedge clk) disable iff (rst)
    (|(sw_trig & MASK)) |=> ((pend_out & $past(sw_trig & MASK)) == $past(sw_trig & MASK)));
  // R6, R7, R8: flags on denied bits survive a write
  a_r8_denied_write_keeps: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ((pend_out & $past(pend_out & ~ok_c)) == $past(pend_out & ~ok_c)));
  // R8: denied bits read as 0
  a_r8_denied_read_zero: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> ((rdata[N-1:0] & ~$past(ok_c)) == '0));
  // R3: a flag only rises with a cause
  a_r3_no_spurious_set: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend_out & ~$past(pend_out) & ~$past(sw_trig | rise)) == '0));
  // R10
  a_r10_absent_zero: assert property (@(posedge clk) disable iff (rst)
    (pend_out & ~MASK) == '0);
  // R11
  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

bind rise_pend_bank rpb_checker #(.N(NLINES), .MASK(LINE_MASK)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .acc_secure (acc_secure),
  .acc_priv   (acc_priv),
  .sec_cfg    (sec_cfg),
  .priv_cfg   (priv_cfg),
  .sw_trig    (sw_trig),
  .rise       (rise_vec),
  .pend_out   (pend_out),
  .rdata      (rdata)
);

// File: tb/tb_rise_pend_bank.sv
module tb_rise_pend_bank;
  localparam int N = 26;
  localparam logic [N-1:0] MASK = 26'h2FF_FFFF; // line 24 absent

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] evt_in = '0, sw_trig = '0, sec_cfg = '0, priv_cfg = '0;
  logic wr_en = 1'b0, rd_en = 1'b0, acc_secure = 1'b0, acc_priv = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [N-1:0] pend_out;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  rise_pend_bank #(.NLINES(N), .LINE_MASK(MASK)) dut (
    .clk(clk), .rst(rst), .evt_in(evt_in), .sw_trig(sw_trig),
    .sec_cfg(sec_cfg), .priv_cfg(priv_cfg), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .acc_secure(acc_secure), .acc_priv(acc_priv),
    .rdata(rdata), .pend_out(pend_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [N-1:0] ok_mask(input logic s, input logic p);
    return MASK & ({N{s}} | ~sec_cfg) & ({N{p}} | ~priv_cfg);
  endfunction

  task automatic trig(input logic [N-1:0] v);
    sw_trig = v; tick(); sw_trig = '0;
  endtask

  task automatic do_read(input logic s, input logic p);
    acc_secure = s; acc_priv = p; rd_en = 1'b1; tick(); rd_en = 1'b0;
  endtask

  task automatic do_write(input logic s, input logic p, input logic [31:0] d);
    acc_secure = s; acc_priv = p; wdata = d; wr_en = 1'b1; tick(); wr_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] held;
    @(negedge clk); tick(); tick();
    chk("R2 pend in reset", 32'(pend_out), 32'h0);
    chk("R2 rdata in reset", rdata, 32'h0);
    rst = 1'b0; tick();
    chk("R2 pend after reset", 32'(pend_out), 32'h0);

    // R4 / R10: trigger every line, absent line stays 0
    trig('1);
    chk("R4 R10 trigger all", 32'(pend_out), 32'(MASK));
    do_read(1'b1, 1'b1);
    chk("R1 R11 full read", rdata, {6'b0, MASK});

    // R6 R7 R8: sweep attributes against interleaved configs
    sec_cfg  = 26'h2AA_AAAA;
    priv_cfg = 26'h333_3333;
    for (int a = 0; a < 4; a++) begin
      logic s, p;
      s = a[1]; p = a[0];
      trig('1);
      do_read(s, p);
      chk("R6 R7 R8 filtered read", rdata, 32'(ok_mask(s, p)));
      do_write(s, p, 32'hFFFF_FFFF);
      chk("R6 R7 R8 filtered clear", 32'(pend_out), 32'(MASK & ~ok_mask(s, p)));
      do_read(1'b1, 1'b1);
      chk("R8 readback after clear", rdata, 32'(MASK & ~ok_mask(1'b1, 1'b1) & ~ok_mask(s, p)
                                             | (MASK & ~ok_mask(s, p) & ok_mask(1'b1, 1'b1))));
    end
    sec_cfg = '0; priv_cfg = '0;

    // R5: write 0 leaves, write 1 clears selected bits
    trig('1);
    do_write(1'b0, 1'b0, 32'h0);
    chk("R5 write zero keeps", 32'(pend_out), 32'(MASK));
    do_write(1'b0, 1'b0, 32'h0000_00F0);
    chk("R5 partial clear", 32'(pend_out), 32'(MASK & ~26'h00000F0));
    do_write(1'b0, 1'b0, 32'hFFFF_FFFF);
    chk("R5 clear all", 32'(pend_out), 32'h0);

    // R3: edge path latency
    evt_in[3] = 1'b1;
    tick(); tick();
    chk("R3 not yet after two edges", 32'(pend_out), 32'h0);
    tick();
    chk("R3 set after third edge", 32'(pend_out), 32'h8);
    do_write(1'b1, 1'b1, 32'h8);
    repeat (5) tick();
    chk("R3 steady level no reset", 32'(pend_out), 32'h0);
    evt_in[3] = 1'b0;
    repeat (5) tick();
    chk("R3 falling no set", 32'(pend_out), 32'h0);

    // R10: absent line 24 ignores edge, trigger and reads 0
    evt_in[24] = 1'b1; sw_trig[24] = 1'b1; tick(); sw_trig = '0;
    repeat (5) tick();
    chk("R10 absent line pend", 32'(pend_out), 32'h0);
    do_read(1'b1, 1'b1);
    chk("R10 absent line read", rdata, 32'h0);
    evt_in = '0;
    repeat (4) tick();

    // R9: set beats clear in the same cycle
    trig(26'h20);
    sw_trig = 26'h20; wdata = 32'h20; wr_en = 1'b1; acc_secure = 1'b1; acc_priv = 1'b1;
    tick();
    sw_trig = '0; wr_en = 1'b0;
    chk("R9 set wins", 32'(pend_out), 32'h20);

    // R11: rdata holds without rd_en
    do_read(1'b1, 1'b1);
    held = rdata;
    chk("R11 read value", held, 32'h20);
    trig(26'h3);
    do_write(1'b1, 1'b1, 32'h20);
    chk("R11 rdata held", rdata, held);
    do_read(1'b1, 1'b1);
    chk("R11 reload", rdata, 32'h3);

    // R2: reset mid-run
    rst = 1'b1; tick(); rst = 1'b0;
    chk("R2 reset clears flags", 32'(pend_out), 32'h0);
    chk("R2 reset clears rdata", rdata, 32'h0);

    finish_run();
  end
endmodule